// File: doc/BRIEF.md
# ChaCha20 Keystream Block Generator

This block turns a 256-bit key, a 96-bit nonce and a 32-bit block counter into one 512-bit ChaCha20 keystream block. A start request captures the three inputs and forms the sixteen-word starting matrix. A single add-rotate-XOR quarter-round unit then runs once per clock for all eighty quarter-round steps of the twenty rounds. A step sequencer steps that unit through the column and diagonal word groups. At the end the starting matrix is added back word by word, and the block is held on a valid/ready output until it is taken.

The block is meant to sit beside a stream XOR stage or an authenticator that uses keystream blocks. The caller raises the start input while the ready output is high. It then waits for valid and takes the block with a ready handshake. Each new block counter value gives a different block.

Top module: `ks_block_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ready_o is 1, blk_valid_o is 0 and done_o is 0.
- R2: The starting matrix is as follows. Words 0..3 are 0x61707865, 0x3320646e, 0x79622d32 and 0x6b206574. Word 4+k is key_i[32k+31:32k] for k = 0..7. Word 12 is ctr_i. Word 13+j is nonce_i[32j+31:32j] for j = 0..2.
- R3: The mixing is twenty rounds. Even rounds (counting from 0) apply the quarter round to the groups (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15), in that order. Odd rounds apply it to (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14). A quarter round on (a,b,c,d) does a+=b, d^=a, d<<<=16, c+=d, b^=c, b<<<=12, a+=b, d^=a, d<<<=8, c+=d, b^=c, b<<<=7. Additions are modulo 2^32 and rotations are to the left.
- R4: Output word i is the mixed word i plus starting word i, modulo 2^32. It appears on blk_data_o[32i+31:32i].
- R5: blk_valid_o is first seen high in the cycle after the 81st rising edge that follows the edge at which start is accepted.
- R6: done_o is high for exactly one cycle: the first cycle in which blk_valid_o is high.
- R7: While blk_valid_o is high and blk_ready_i is low, blk_valid_o stays high and blk_data_o does not change.
- R8: ready_o falls at the edge that accepts start. It rises at the edge where blk_valid_o and blk_ready_i are both high, and blk_valid_o falls at that same edge. ready_o and blk_valid_o are never high together.
- R9: A start request while ready_o is low has no effect on the block being computed or on its timing.
- R10: A counter value of 0xFFFFFFFF is used as is, with no carry into the nonce words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a block; taken only while ready_o is high |
| key_i | input | 256 | Key, word k at bits 32k+31:32k |
| nonce_i | input | 96 | Nonce, word j at bits 32j+31:32j |
| ctr_i | input | 32 | Block counter |
| ready_o | output | 1 | Idle and able to accept start |
| blk_valid_o | output | 1 | Keystream block on blk_data_o is valid |
| blk_ready_i | input | 1 | Consumer takes the block |
| blk_data_o | output | 512 | Keystream block, word i at bits 32i+31:32i |
| done_o | output | 1 | One-cycle pulse marking a finished block |

## Verification
A wrong word index from the step sequencer, a wrong rotation or a lost write in the state bank does not show until the block comes out. It then corrupts nearly every output word, about 81 cycles after start. So each block is compared in full against a behavioural block function and against the published test vector. An error in the phase control shows sooner. A step-count or handshake fault moves valid, done or ready away from the predicted cycle, and the bench's per-clock model catches that in the first cycle it happens.

// File: rtl/ks_pkg.sv
// Package: shared word types, the fixed constant row, the rotate helper and
// the mapping from a quarter-round slot to the four state word indices.
package ks_pkg;

    localparam int WORD_W = 32;
    localparam int NWORDS = 16;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NWORDS-1:0][WORD_W-1:0] state_t;

    // Four word indices that feed one quarter round.
    typedef struct packed {
        logic [3:0] a;
        logic [3:0] b;
        logic [3:0] c;
        logic [3:0] d;
    } qsel_t;

    // Constant word for row 0, position i.
    function automatic word_t const_word(input int unsigned i);
        case (i)
            0:       return 32'h61707865;
            1:       return 32'h3320646e;
            2:       return 32'h79622d32;
            default: return 32'h6b206574;
        endcase
    endfunction

    // Left rotate by a fixed amount.
    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // Column slot q uses column q; diagonal slot q shifts each row by its number.
    function automatic qsel_t qr_select(input logic diag, input logic [1:0] q);
        qsel_t      s;
        logic [1:0] qb, qc, qd;
        qb  = diag ? q + 2'd1 : q;
        qc  = diag ? q + 2'd2 : q;
        qd  = diag ? q + 2'd3 : q;
        s.a = {2'b00, q};
        s.b = {2'b01, qb};
        s.c = {2'b10, qc};
        s.d = {2'b11, qd};
        return s;
    endfunction

endpackage

// File: rtl/ks_qround.sv
// Module: one add-rotate-XOR quarter round, purely combinational.
// Assumes: the caller registers the results; the depth is four adders in series.
module ks_qround
    import ks_pkg::*;
(
    input  word_t a_i,
    input  word_t b_i,
    input  word_t c_i,
    input  word_t d_i,
    output word_t a_o,
    output word_t b_o,
    output word_t c_o,
    output word_t d_o
);

    word_t a1, b1, c1, d1;
    word_t a2, b2, c2, d2;

    // Two half steps, each of add, XOR and rotate on the pairs (a,d) and (c,b).
    always_comb begin
        a1  = a_i + b_i;
        d1  = rotl(d_i ^ a1, 16);
        c1  = c_i + d1;
        b1  = rotl(b_i ^ c1, 12);
        a2  = a1 + b1;
        d2  = rotl(d1 ^ a2, 8);
        c2  = c1 + d2;
        b2  = rotl(b1 ^ c2, 7);
        a_o = a2;
        b_o = b2;
        c_o = c2;
        d_o = d2;
    end

endmodule

// File: rtl/ks_sequencer.sv
// Module: phase control and step counter for the block generator.
// Phases are idle, mixing (one quarter round per clock), final add, and output hold.
// Assumes: NUM_ROUNDS is even, so the last round is a diagonal round.
module ks_sequencer
    import ks_pkg::*;
#(
    parameter int NUM_ROUNDS = 20
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  logic  out_ready_i,
    output logic  ready_o,
    output logic  load_o,
    output logic  run_o,
    output logic  fin_o,
    output logic  valid_o,
    output logic  done_o,
    output qsel_t sel_o
);

    localparam int STEPS  = NUM_ROUNDS * 4;
    localparam int STEP_W = $clog2(STEPS);

    typedef enum logic [1:0] {PH_IDLE, PH_MIX, PH_ADD, PH_HOLD} phase_t;

    phase_t            phase_q;
    logic [STEP_W-1:0] step_q;
    logic              done_q;
    logic              last_step;

    assign last_step = (step_q == STEP_W'(STEPS - 1));
    assign ready_o   = (phase_q == PH_IDLE);
    assign load_o    = ready_o && start_i;
    assign run_o     = (phase_q == PH_MIX);
    assign fin_o     = (phase_q == PH_ADD);
    assign valid_o   = (phase_q == PH_HOLD);
    assign done_o    = done_q;

    // Step bit 2 is the round parity (diagonal when set); bits 1:0 pick the slot.
    always_comb begin
        sel_o = qr_select(step_q[2], step_q[1:0]);
    end

    // Phase transitions and step counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start_i) begin
                    phase_q <= PH_MIX;
                    step_q  <= '0;
                end
                PH_MIX: begin
                    step_q <= step_q + STEP_W'(1);
                    if (last_step) phase_q <= PH_ADD;
                end
                PH_ADD:  phase_q <= PH_HOLD;
                default: if (out_ready_i) phase_q <= PH_IDLE;
            endcase
        end
    end

    // Done pulse: set by the final add, so it lines up with the first hold cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= fin_o;
    end

endmodule

// File: rtl/ks_state_bank.sv
// Module: the sixteen working words and the saved starting matrix.
// On load both take the matrix built from the inputs. On each mixing step the
// four selected words are replaced. On the final add each working word gains
// its starting word.
// Assumes: load, run and fin are mutually exclusive.
module ks_state_bank
    import ks_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           run_i,
    input  logic           fin_i,
    input  logic [255:0]   key_i,
    input  logic [95:0]    nonce_i,
    input  logic [31:0]    ctr_i,
    input  qsel_t          sel_i,
    input  word_t          na_i,
    input  word_t          nb_i,
    input  word_t          nc_i,
    input  word_t          nd_i,
    output word_t          qa_o,
    output word_t          qb_o,
    output word_t          qc_o,
    output word_t          qd_o,
    output state_t         work_o
);

    state_t start_mx;
    state_t init_q;
    state_t work_q;

    // Starting matrix: constant row, key rows, then counter and nonce.
    for (genvar i = 0; i < 4; i++) begin : g_const
        assign start_mx[i] = const_word(i);
    end
    for (genvar k = 0; k < 8; k++) begin : g_key
        assign start_mx[4 + k] = key_i[32*k +: 32];
    end
    assign start_mx[12] = ctr_i;
    for (genvar j = 0; j < 3; j++) begin : g_nonce
        assign start_mx[13 + j] = nonce_i[32*j +: 32];
    end

    // Read ports for the quarter-round unit.
    assign qa_o   = work_q[sel_i.a];
    assign qb_o   = work_q[sel_i.b];
    assign qc_o   = work_q[sel_i.c];
    assign qd_o   = work_q[sel_i.d];
    assign work_o = work_q;

    // Save the starting matrix for the final add.
    always_ff @(posedge clk) begin
        if (!rst_n)      init_q <= '0;
        else if (load_i) init_q <= start_mx;
    end

    // Working words: load, quarter-round write-back, or final add.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
        end else if (load_i) begin
            work_q <= start_mx;
        end else if (run_i) begin
            work_q[sel_i.a] <= na_i;
            work_q[sel_i.b] <= nb_i;
            work_q[sel_i.c] <= nc_i;
            work_q[sel_i.d] <= nd_i;
        end else if (fin_i) begin
            for (int i = 0; i < NWORDS; i++) work_q[i] <= work_q[i] + init_q[i];
        end
    end

endmodule

// File: rtl/ks_block_gen.sv
// Module: top of the keystream block generator. It ties the sequencer, the
// state bank and the one shared quarter-round unit together.
// Assumes: the consumer accepts the block with blk_ready_i while blk_valid_o is high.
module ks_block_gen
    import ks_pkg::*;
#(
    parameter int NUM_ROUNDS = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [255:0] key_i,
    input  logic [95:0]  nonce_i,
    input  logic [31:0]  ctr_i,
    output logic         ready_o,
    output logic         blk_valid_o,
    input  logic         blk_ready_i,
    output logic [511:0] blk_data_o,
    output logic         done_o
);

    qsel_t  sel;
    logic   load, run, fin;
    word_t  qa, qb, qc, qd;
    word_t  na, nb, nc, nd;
    state_t work;

    ks_sequencer #(.NUM_ROUNDS(NUM_ROUNDS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .out_ready_i (blk_ready_i),
        .ready_o     (ready_o),
        .load_o      (load),
        .run_o       (run),
        .fin_o       (fin),
        .valid_o     (blk_valid_o),
        .done_o      (done_o),
        .sel_o       (sel)
    );

    ks_state_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .run_i   (run),
        .fin_i   (fin),
        .key_i   (key_i),
        .nonce_i (nonce_i),
        .ctr_i   (ctr_i),
        .sel_i   (sel),
        .na_i    (na),
        .nb_i    (nb),
        .nc_i    (nc),
        .nd_i    (nd),
        .qa_o    (qa),
        .qb_o    (qb),
        .qc_o    (qc),
        .qd_o    (qd),
        .work_o  (work)
    );

    ks_qround u_qr (
        .a_i (qa), .b_i (qb), .c_i (qc), .d_i (qd),
        .a_o (na), .b_o (nb), .c_o (nc), .d_o (nd)
    );

    assign blk_data_o = work;

endmodule

// File: rtl/ks_block_gen_chk.sv
// Module: protocol and timing checker, bound to the top module.
// It counts cycles since start was accepted so that the latency window is
// checked without a deep $past.
module ks_block_gen_chk #(
    parameter int NUM_ROUNDS = 20
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         ready_o,
    input logic         blk_valid_o,
    input logic         blk_ready_i,
    input logic [511:0] blk_data_o,
    input logic         done_o
);

    localparam int LAT = NUM_ROUNDS * 4 + 1;

    logic [15:0] since_start;

    // Cycle counter from the accepting edge; it saturates when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                   since_start <= '1;
        else if (start_i && ready_o)  since_start <= '0;
        else if (since_start != '1)   since_start <= since_start + 16'd1;
    end

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_valid_o) |-> since_start == 16'(LAT));

    p_done_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> blk_valid_o);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid_o && !blk_ready_i) |=> (blk_valid_o && $stable(blk_data_o)));

    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && blk_valid_o));

    p_handshake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid_o && blk_ready_i) |=> (ready_o && !blk_valid_o));

    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !ready_o && !(blk_valid_o && blk_ready_i)) |=> !ready_o);

endmodule

bind ks_block_gen ks_block_gen_chk #(.NUM_ROUNDS(NUM_ROUNDS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ready_o     (ready_o),
    .blk_valid_o (blk_valid_o),
    .blk_ready_i (blk_ready_i),
    .blk_data_o  (blk_data_o),
    .done_o      (done_o)
);

// File: tb/ks_block_gen_tb.sv
// Bench: a behavioural model predicts ready, valid, done and the data in every
// cycle, and it is compared at each falling edge. Directed checks cover the
// published vector, stalls, ignored starts and an all-ones counter.
module ks_block_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 81;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [255:0] key_i = '0;
    logic [95:0]  nonce_i = '0;
    logic [31:0]  ctr_i = '0;
    logic         ready_o, blk_valid_o, done_o;
    logic         blk_ready_i = 1'b0;
    logic [511:0] blk_data_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit live   = 0;

    // Behavioural model state.
    bit           m_busy = 0, m_valid = 0, m_done = 0;
    int           m_cnt = 0;
    logic [511:0] m_data = '0;

    ks_block_gen u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .key_i (key_i), .nonce_i (nonce_i), .ctr_i (ctr_i),
        .ready_o (ready_o), .blk_valid_o (blk_valid_o), .blk_ready_i (blk_ready_i),
        .blk_data_o (blk_data_o), .done_o (done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    // Reference keystream block, written from the requirements with arrays.
    function automatic logic [511:0] ref_block(input logic [255:0] k,
                                               input logic [95:0] n,
                                               input logic [31:0] c);
        logic [31:0] s[16];
        logic [31:0] x[16];
        int          g[8][4];
        logic [511:0] r;
        int colg[4][4] = '{'{0,4,8,12}, '{1,5,9,13}, '{2,6,10,14}, '{3,7,11,15}};
        int diag[4][4] = '{'{0,5,10,15}, '{1,6,11,12}, '{2,7,8,13}, '{3,4,9,14}};
        s[0] = 32'h61707865; s[1] = 32'h3320646e; s[2] = 32'h79622d32; s[3] = 32'h6b206574;
        for (int i = 0; i < 8; i++) s[4+i] = k[32*i +: 32];
        s[12] = c;
        for (int i = 0; i < 3; i++) s[13+i] = n[32*i +: 32];
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                g[i][j]   = colg[i][j];
                g[4+i][j] = diag[i][j];
            end
        x = s;
        for (int rnd = 0; rnd < 20; rnd++)
            for (int q = 0; q < 4; q++) begin
                int a, b, cc, d;
                a = g[(rnd%2)*4+q][0]; b = g[(rnd%2)*4+q][1];
                cc = g[(rnd%2)*4+q][2]; d = g[(rnd%2)*4+q][3];
                x[a] = x[a] + x[b]; x[d] = rl(x[d] ^ x[a], 16);
                x[cc] = x[cc] + x[d]; x[b] = rl(x[b] ^ x[cc], 12);
                x[a] = x[a] + x[b]; x[d] = rl(x[d] ^ x[a], 8);
                x[cc] = x[cc] + x[d]; x[b] = rl(x[b] ^ x[cc], 7);
            end
        for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i] + s[i];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [511:0] act,
                         input logic [511:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Model update at each rising edge, from the inputs only.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_valid = 0; m_done = 0; m_cnt = 0;
        end else begin
            m_done = 0;
            if (!m_busy && start_i) begin
                m_busy = 1; m_cnt = 0; m_data = ref_block(key_i, nonce_i, ctr_i);
            end else if (m_busy && !m_valid) begin
                m_cnt++;
                if (m_cnt == LAT) begin m_valid = 1; m_done = 1; end
            end else if (m_valid && blk_ready_i) begin
                m_valid = 0; m_busy = 0;
            end
        end
        if (cycles > WATCHDOG) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (live) begin
            check(ready_o == !m_busy, "R8 ready", 512'(ready_o), 512'(!m_busy));
            check(blk_valid_o == m_valid, "R5 valid", 512'(blk_valid_o), 512'(m_valid));
            check(done_o == m_done, "R6 done", 512'(done_o), 512'(m_done));
            if (m_valid)
                check(blk_data_o == m_data, "R4/R7 data", blk_data_o, m_data);
        end
    end

    task automatic wait_valid(input bit poke, input logic [255:0] other);
        int n = 0;
        while (!blk_valid_o) begin
            @(negedge clk);
            n++;
            if (poke && n == 10) begin start_i = 1'b1; key_i = other; end
            else start_i = 1'b0;
        end
    endtask

    task automatic run_block(input logic [255:0] k, input logic [95:0] n,
                             input logic [31:0] c, input int stall, input bit poke);
        @(negedge clk);
        key_i = k; nonce_i = n; ctr_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_valid(poke, ~k);
        for (int i = 0; i < stall; i++) begin
            start_i = (poke && i == 1);
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    task automatic take_block();
        blk_ready_i = 1'b1;
        @(negedge clk);
        blk_ready_i = 1'b0;
    endtask

    logic [255:0] vkey;
    logic [511:0] vexp;

    initial begin
        for (int j = 0; j < 32; j++) vkey[8*j +: 8] = 8'(j);
        vexp = {32'h4e3c50a2, 32'he883d0cb, 32'hb94e16de, 32'hd19c12b5,
                32'ha2028bd9, 32'h05d7c214, 32'h09aa9f07, 32'h466482d2,
                32'h4e6cd4c3, 32'h9aaa2204, 32'h0368c033, 32'hc7f4d1c7,
                32'hc47120a3, 32'h1fdd0f50, 32'h15593bd1, 32'he4e7f110};

        repeat (3) @(negedge clk);
        check(ready_o && !blk_valid_o && !done_o, "R1 reset",
              512'({ready_o, blk_valid_o, done_o}), 512'(3'b100));
        rst_n = 1'b1;
        @(negedge clk);
        check(ready_o && !blk_valid_o && !done_o, "R1 after reset",
              512'({ready_o, blk_valid_o, done_o}), 512'(3'b100));
        live = 1;

        // R2, R3: published vector, checked against a fixed value and the model.
        run_block(vkey, 96'h00000000_4a000000_09000000, 32'd1, 0, 0);
        check(blk_data_o == vexp, "R3 vector", blk_data_o, vexp);
        check(ref_block(vkey, 96'h00000000_4a000000_09000000, 32'd1) == vexp,
              "R2 model vector", ref_block(vkey, 96'h00000000_4a000000_09000000, 32'd1), vexp);
        take_block();

        // R7, R9: stall with starts while busy; the block must stay the first key's.
        run_block({8{32'hdeadbeef}}, 96'h0123456789abcdef01234567, 32'h5, 6, 1);
        check(blk_data_o == ref_block({8{32'hdeadbeef}}, 96'h0123456789abcdef01234567, 32'h5),
              "R9 busy start ignored", blk_data_o,
              ref_block({8{32'hdeadbeef}}, 96'h0123456789abcdef01234567, 32'h5));
        take_block();

        // R10: all-ones counter, compared directly to the reference.
        run_block({8{32'h0f1e2d3c}}, 96'hffffffff_00000000_12345678, 32'hffffffff, 2, 0);
        check(blk_data_o == ref_block({8{32'h0f1e2d3c}}, 96'hffffffff_00000000_12345678, 32'hffffffff),
              "R10 counter wrap", blk_data_o,
              ref_block({8{32'h0f1e2d3c}}, 96'hffffffff_00000000_12345678, 32'hffffffff));
        take_block();

        // R8: back-to-back start right after the handshake.
        run_block('0, '0, '0, 0, 0);
        check(blk_data_o == ref_block('0, '0, '0), "R4 zero key", blk_data_o,
              ref_block('0, '0, '0));
        take_block();
        check(ready_o == 1'b1, "R8 ready after take", 512'(ready_o), 512'(1));

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule